// File: doc/BRIEF.md
# Two-Bank Memory-Mapped Interrupt Controller

This block collects up to 64 interrupt source lines into two banks of 32 and presents them to a processor through a small word-addressed register window of 0x40 bytes. Each bank has four word registers: a latched event register, an enable mask, a write-one-to-clear acknowledge port and a live level view. Every source carries a configuration bit. An edge source raises a request only through its latched event. A level source also raises a request for as long as its line is high.

One request line goes to the processor. Software reads the banks, chooses which source to serve and acknowledges it. Source lines are synchronised through two flip-flops before any edge is detected. An event is latched only on a rising edge that arrives while the source is enabled. Enabling a source whose line is already high therefore does not latch an event, and software must retrigger such a source itself.

Top module: `legacy_irq_ctrl`

## Requirements
- R1: Sources 0 to 31 use the bank based at byte offset 0x20, and sources 32 to 63 use the bank based at 0x10. Within a bank, the event, enable, ack and level words sit at +0x0, +0x4, +0x8 and +0xC. Source n is data bit n&31 of its bank word. Address bits [1:0] are ignored.
- R2: A read of an enable word returns the value last written to it.
- R3: An event bit is set by a rising edge of its synchronised source line, but only while its enable bit is set. It then stays set after the line falls. The event is visible no later than the fourth clock edge after the input changes.
- R4: Writing a 1 to a bit of an ack word clears the matching event bit. Bits written as 0 leave their event bits unchanged.
- R5: For an edge source, writing its enable bit while its line is already high sets no event bit and leaves the request low.
- R6: A level word returns the synchronised raw state of its 32 lines, whether or not those sources are enabled.
- R7: irq_out is high exactly when, for some source, (event OR (level_mode AND live line)) AND enable is 1, taken across both banks. Writing zero to both enable words drops irq_out even while events stay latched.
- R8: Reads of ack words and of unmapped offsets (0x00 to 0x0C and 0x30 to 0x3C) return zero. Read data appears on bus_rdata one clock edge after bus_re is sampled.
- R9: Reset clears every event and enable bit and holds irq_out low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Byte offset into the register window |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, registered |
| src_in | input | 64 | Raw source lines, asynchronous |
| src_level | input | 64 | Per-source mode: 1 means level, 0 means edge |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The assertions assume that bus_we and bus_re are never high in the same cycle. They also assume that src_level is held still while a source is active, because the mode bit feeds the request logic directly without a synchroniser. The stimulus issues each bus access alone, sets the mode bits only while the lines are low, and waits several cycles after every line change so the synchroniser has settled before anything is read.

// File: rtl/legacy_irq_ctrl.sv
module legacy_irq_ctrl #(
  parameter int BANK_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [5:0]            bus_addr,
  input  logic                  bus_we,
  input  logic [BANK_W-1:0]     bus_wdata,
  input  logic                  bus_re,
  output logic [BANK_W-1:0]     bus_rdata,
  input  logic [2*BANK_W-1:0]   src_in,
  input  logic [2*BANK_W-1:0]   src_level,
  output logic                  irq_out
);
  localparam int NSRC = 2 * BANK_W;

  logic [NSRC-1:0] sync1, sync2, sync3;
  logic [NSRC-1:0] event_q, enable_q;
  logic [NSRC-1:0] rise, ack_mask;
  logic [3:0]      word;

  assign word = bus_addr[5:2];
  assign rise = sync2 & ~sync3;

  assign ack_mask = {(bus_we && word == 4'h6) ? bus_wdata : '0,
                     (bus_we && word == 4'hA) ? bus_wdata : '0};

  always_ff @(posedge clk) begin
    sync1 <= src_in;
    sync2 <= sync1;
    sync3 <= sync2;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      event_q  <= '0;
      enable_q <= '0;
    end else begin
      event_q <= (event_q & ~ack_mask) | (rise & enable_q);
      if (bus_we && word == 4'h9) enable_q[BANK_W-1:0]    <= bus_wdata;
      if (bus_we && word == 4'h5) enable_q[NSRC-1:BANK_W] <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_re) begin
      case (word)
        4'h8:    bus_rdata <= event_q[BANK_W-1:0];
        4'h9:    bus_rdata <= enable_q[BANK_W-1:0];
        4'hB:    bus_rdata <= sync2[BANK_W-1:0];
        4'h4:    bus_rdata <= event_q[NSRC-1:BANK_W];
        4'h5:    bus_rdata <= enable_q[NSRC-1:BANK_W];
        4'h7:    bus_rdata <= sync2[NSRC-1:BANK_W];
        default: bus_rdata <= '0;
      endcase
    end
  end

  assign irq_out = |((event_q | (sync2 & src_level)) & enable_q);
endmodule

// File: rtl/legacy_irq_ctrl_chk.sv
module legacy_irq_ctrl_chk #(
  parameter int BANK_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic [5:0]          bus_addr,
  input logic                bus_we,
  input logic [BANK_W-1:0]   bus_wdata,
  input logic                bus_re,
  input logic [BANK_W-1:0]   bus_rdata,
  input logic                irq_out,
  input logic [2*BANK_W-1:0] event_q,
  input logic [2*BANK_W-1:0] enable_q
);
  logic [2*BANK_W-1:0] clr;
  logic                unmapped;
  assign clr = {(bus_we && bus_addr[5:2] == 4'h6) ? bus_wdata : {BANK_W{1'b0}},
                (bus_we && bus_addr[5:2] == 4'hA) ? bus_wdata : {BANK_W{1'b0}}};
  assign unmapped = bus_addr[5:4] == 2'b00 || bus_addr[5:4] == 2'b11 ||
                    bus_addr[3:2] == 2'b10;

  a_r3_event_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    ((event_q & ~$past(event_q)) & ~$past(enable_q)) == '0);

  a_r4_clear_only_by_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(event_q) & ~event_q) & ~$past(clr)) == '0);

  a_r2_enable_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr[5:2] == 4'h9) |=> (enable_q[BANK_W-1:0] == $past(bus_wdata)));

  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && unmapped) |=> (bus_rdata == '0));

  a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_q == '0) |-> !irq_out);
endmodule

bind legacy_irq_ctrl legacy_irq_ctrl_chk #(.BANK_W(BANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
  .irq_out(irq_out), .event_q(event_q), .enable_q(enable_q)
);

// File: tb/legacy_irq_ctrl_bench.sv
`timescale 1ns/1ps
module legacy_irq_ctrl_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [5:0]  bus_addr = 0;
  logic        bus_we = 0;
  logic [31:0] bus_wdata = 0;
  logic        bus_re = 0;
  logic [31:0] bus_rdata;
  logic [63:0] src_in = 0;
  logic [63:0] src_level = 0;
  logic        irq_out;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  legacy_irq_ctrl u_legacy_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .src_in(src_in), .src_level(src_level), .irq_out(irq_out)
  );

  // {write, addr, data-or-expected}
  localparam logic [38:0] VEC [0:7] = '{
    {1'b1, 6'h24, 32'h0000_000F},
    {1'b0, 6'h24, 32'h0000_000F},
    {1'b1, 6'h14, 32'h8000_0001},
    {1'b0, 6'h14, 32'h8000_0001},
    {1'b0, 6'h26, 32'h0000_000F},
    {1'b0, 6'h20, 32'h0000_0000},
    {1'b0, 6'h00, 32'h0000_0000},
    {1'b0, 6'h30, 32'h0000_0000}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1;
    @(negedge clk);
    bus_re = 0;
    d = bus_rdata;
  endtask

  task automatic rdchk(string req, logic [5:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R9 reset state
    check("R9 irq", {31'b0, irq_out}, 32'h0);
    rdchk("R9 enable0", 6'h24, 32'h0);
    rdchk("R9 enable1", 6'h14, 32'h0);
    rdchk("R9 event0", 6'h20, 32'h0);

    // R2 R8 R1 table
    for (int i = 0; i < 8; i++) begin
      if (VEC[i][38]) wr(VEC[i][37:32], VEC[i][31:0]);
      else rdchk("R2/R8 table", VEC[i][37:32], VEC[i][31:0]);
    end

    // R3 edge latch, sticky
    src_in[1] = 1; settle();
    rdchk("R3 event set", 6'h20, 32'h0000_0002);
    check("R7 irq on event", {31'b0, irq_out}, 32'h1);
    rdchk("R6 level0", 6'h2C, 32'h0000_0002);
    src_in[1] = 0; settle();
    rdchk("R3 sticky", 6'h20, 32'h0000_0002);
    // R4 ack
    wr(6'h28, 32'h0000_0001);
    rdchk("R4 zero bits kept", 6'h20, 32'h0000_0002);
    wr(6'h28, 32'h0000_0002);
    rdchk("R4 cleared", 6'h20, 32'h0);
    check("R4 irq low", {31'b0, irq_out}, 32'h0);
    rdchk("R8 ack reads zero", 6'h28, 32'h0);

    // R1 bank1 mapping, disabled source
    src_in[33] = 1; settle();
    rdchk("R3 disabled no event", 6'h10, 32'h0);
    rdchk("R1 R6 level1", 6'h1C, 32'h0000_0002);
    check("R3 irq low", {31'b0, irq_out}, 32'h0);
    // R5 enable while high
    wr(6'h14, 32'h8000_0003); settle();
    rdchk("R5 no event", 6'h10, 32'h0);
    check("R5 no request", {31'b0, irq_out}, 32'h0);
    src_in[33] = 0; settle();
    src_in[33] = 1; settle();
    rdchk("R1 bank1 event", 6'h10, 32'h0000_0002);
    rdchk("R1 bank0 untouched", 6'h20, 32'h0);
    check("R7 irq bank1", {31'b0, irq_out}, 32'h1);
    wr(6'h18, 32'h0000_0002);
    rdchk("R4 bank1 clear", 6'h10, 32'h0);
    src_in[33] = 0; settle();

    // R7 level mode
    src_level[2] = 1;
    src_in[2] = 1; settle();
    rdchk("R3 level src event", 6'h20, 32'h0000_0004);
    wr(6'h28, 32'h0000_0004);
    rdchk("R4 level src clear", 6'h20, 32'h0);
    check("R7 level holds irq", {31'b0, irq_out}, 32'h1);
    src_in[2] = 0; settle();
    check("R7 level released", {31'b0, irq_out}, 32'h0);
    src_level[2] = 0;

    // R7 mask-all
    src_in[63] = 1; settle();
    rdchk("R1 src63", 6'h10, 32'h8000_0000);
    check("R7 irq src63", {31'b0, irq_out}, 32'h1);
    wr(6'h24, 32'h0); wr(6'h14, 32'h0);
    @(negedge clk);
    check("R7 masked", {31'b0, irq_out}, 32'h0);
    rdchk("R7 event kept", 6'h10, 32'h8000_0000);
    rdchk("R2 enable zero", 6'h24, 32'h0);
    wr(6'h18, 32'h8000_0000);
    rdchk("R4 src63 clear", 6'h10, 32'h0);
    src_in[63] = 0;

    // R6 level while disabled
    src_in[5] = 1; settle();
    rdchk("R6 disabled level", 6'h2C, 32'h0000_0020);

    // R9 reset mid-run
    wr(6'h24, 32'h0000_0020);
    src_in[5] = 0; settle();
    src_in[5] = 1; settle();
    rdchk("R3 src5 event", 6'h20, 32'h0000_0020);
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk); rst_n = 1;
    check("R9 irq after reset", {31'b0, irq_out}, 32'h0);
    rdchk("R9 event cleared", 6'h20, 32'h0);
    rdchk("R9 enable cleared", 6'h24, 32'h0);

    finish_run();
  end
endmodule